// File: doc/BRIEF.md
# Register-Stalled I2C Bus Master

This block is an I2C bus master that software drives through three byte-wide registers: control, status and data. Software writes a start request. The block then issues a Start condition and shifts out the 7-bit slave address with its direction bit. After that it moves data bytes in whichever direction the address selected. SCL and SDA are open-drain: the block only ever pulls a line low and otherwise leaves it to the pull-up.

At every protocol event the block sets an event flag and stops the bus by holding SCL low. The events are Start sent, address done and byte done. The bus stays stopped until software makes a two-step access: a status read first, then the access that belongs to that event. That second access is a data write for Start sent, a control write for address done, and for byte done a data write when transmitting or a data read when receiving. Software picks where the transfer ends by the point at which it sets the stop bit. When there is no transfer, the block leaves both lines alone.

The bit rate comes from the system clock. Each SCL period takes four phases of `DIV` clocks each. Register accesses are single-cycle strobes. Read data is combinational from the addressed register. There is no streamed data path, so no valid/ready handshake applies.

Top module: `i2c_evt_master`

## Requirements
- R1: After reset the status (address 1) and control (address 0) registers read 0x00, `scl_oe`, `sda_oe` and `irq` are low, and no bus activity takes place.
- R2: A control write with START (bit 0) while BUSY (status bit 4) is clear sets MASTER (status bit 5) and puts a Start condition on the bus. BUSY is set from the detected Start until the detected Stop. Once the Start is done, EVF (status bit 0) and SB (status bit 1) are set and SCL is held low.
- R3: An event is cleared only by a status read that happens while EVF is set, followed later by the access that belongs to that event. That access without the earlier status read leaves EVF set, SCL low and the bus idle.
- R4: The data write that clears SB is the address byte, and it goes out MSB first. After its ninth clock, ADR (status bit 3) and EVF are set. NACK (status bit 7) is set if the slave did not acknowledge. ADR is cleared by a status read followed by a control write. If that control write has STOP (bit 1) set, it ends the transfer.
- R5: RXDIR (status bit 6) equals bit 0 of the address byte. A value of 1 selects receive and 0 selects transmit.
- R6: In transmit, after ADR is cleared, each data write sends one byte MSB first. After the ninth clock of each byte, EVF and BTF (status bit 2) are set. A status read followed by a data write clears BTF and sends the byte written.
- R7: In receive, a byte is clocked in as soon as ADR or BTF is cleared. It can be read back at address 2 once EVF and BTF are set. The block drives ACK on the ninth clock if ACK (control bit 2) was set when that byte began. A status read followed by a data read clears BTF.
- R8: In transmit, STOP set after the last data write gives a Stop condition once that byte is done. In receive, STOP set before the last data read gives a Stop condition in place of a further byte. After the Stop, MASTER is clear and both line enables are low.
- R9: If ACK is cleared after the byte-done event of the second-to-last byte and before that byte is read, the last byte is answered with NACK. Every earlier byte is answered with ACK.
- R10: `irq` is high exactly while EVF is set and IE (control bit 3) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe, marks a read for the handshake |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Event interrupt |
| scl_in | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_in | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
Suppose the sequencer state or the handshake arming is wrong. The first sign at the ports is that SCL is released one step too soon or stays low for good. That shows up within one phase of `DIV` clocks after the clearing access. The status byte also shows a missing or extra event bit on the very next poll. A fault in the shifter or the ACK sampling does not show up at an event. It shows up in the bytes and acknowledge bits that a bus slave model records, and the bench compares those against values it computes itself for each transfer. A stuck BUSY or MASTER bit blocks the next start request, so every later transfer hangs at its first event.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;

  typedef enum logic [1:0] {
    CMD_START, CMD_STOP, CMD_WRITE, CMD_READ
  } bus_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_EV_SB, S_ADDR, S_EV_ADDR,
    S_TX_WAIT, S_XFER, S_EV_BTF, S_STOP
  } seq_e;
endpackage

// File: rtl/i2c_evt_tick.sv
module i2c_evt_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || cnt == LAST) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_evt_busmon.sv
module i2c_evt_busmon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic busy
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_now;

  assign scl_now = scl_q[SYNC-1];
  assign sda_s   = sda_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_in};
      sda_q <= {sda_q[SYNC-2:0], sda_in};
      scl_p <= scl_now;
      sda_p <= sda_s;
      if (scl_now && scl_p && sda_p && !sda_s)      busy <= 1'b1;
      else if (scl_now && scl_p && !sda_p && sda_s) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_engine.sv
module i2c_evt_engine
  import i2c_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  bus_cmd_e          cmd,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              ack_out,
  input  logic              sda_s,
  output logic              run,
  output logic              done,
  output logic [BYTE_W-1:0] rbyte,
  output logic              ack_in,
  output logic              scl_lo,
  output logic              sda_lo
);
  localparam int BW = $clog2(BYTE_W + 1);
  localparam logic [BW-1:0] ACK_SLOT = BW'(BYTE_W);

  bus_cmd_e          cmd_q;
  logic [1:0]        ph;
  logic [BW-1:0]     bitn;
  logic [BYTE_W-1:0] sh;
  logic              ack_q;
  logic              is_rd, in_ack;

  assign is_rd  = (cmd_q == CMD_READ);
  assign in_ack = (bitn == ACK_SLOT);
  assign rbyte  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_START;
      ph     <= '0;
      bitn   <= '0;
      sh     <= '0;
      ack_q  <= 1'b0;
      ack_in <= 1'b0;
      run    <= 1'b0;
      done   <= 1'b0;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run && cmd_valid) begin
        run   <= 1'b1;
        cmd_q <= cmd;
        ph    <= '0;
        bitn  <= '0;
        sh    <= wbyte;
        ack_q <= ack_out;
      end else if (run && tick) begin
        ph <= ph + 1'b1;
        case (cmd_q)
          CMD_START: begin
            if (ph == 2'd1) sda_lo <= 1'b1;
            if (ph == 2'd2) begin scl_lo <= 1'b1; run <= 1'b0; done <= 1'b1; end
          end
          CMD_STOP: begin
            if (ph == 2'd0) sda_lo <= 1'b1;
            if (ph == 2'd1) scl_lo <= 1'b0;
            if (ph == 2'd2) begin sda_lo <= 1'b0; run <= 1'b0; done <= 1'b1; end
          end
          default: begin
            case (ph)
              2'd0: begin
                scl_lo <= 1'b1;
                if (in_ack) sda_lo <= is_rd ? ack_q : 1'b0;
                else        sda_lo <= is_rd ? 1'b0 : ~sh[BYTE_W-1];
              end
              2'd1: scl_lo <= 1'b0;
              2'd2: begin
                if (!in_ack)     sh     <= {sh[BYTE_W-2:0], sda_s};
                else if (!is_rd) ack_in <= !sda_s;
              end
              default: begin
                scl_lo <= 1'b1;
                bitn   <= bitn + 1'b1;
                if (in_ack) begin run <= 1'b0; done <= 1'b1; end
              end
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_evt_master.sv
module i2c_evt_master
  import i2c_evt_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe
);
  seq_e st;
  logic ctrl_start, ctrl_stop, ctrl_ack, ctrl_ie;
  logic ev_sb, ev_addr, ev_btf, evf, armed;
  logic master, rxdir, nack;
  logic [BYTE_W-1:0] data_tx, data_rx, eng_rbyte;
  logic cmd_go, tick, eng_run, eng_done, eng_ack, sda_s, bus_busy;
  bus_cmd_e cmd_sel;
  logic sr_rd, dr_rd, dr_wr, cr_wr;

  assign sr_rd = reg_rd && reg_addr == RA_STAT;
  assign dr_rd = reg_rd && reg_addr == RA_DATA;
  assign dr_wr = reg_wr && reg_addr == RA_DATA;
  assign cr_wr = reg_wr && reg_addr == RA_CTRL;
  assign evf   = ev_sb | ev_addr | ev_btf;
  assign irq   = evf & ctrl_ie;

  i2c_evt_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_run), .tick(tick)
  );

  i2c_evt_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .busy(bus_busy)
  );

  i2c_evt_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_go), .cmd(cmd_sel),
    .wbyte(data_tx), .ack_out(ctrl_ack), .sda_s(sda_s), .run(eng_run),
    .done(eng_done), .rbyte(eng_rbyte), .ack_in(eng_ack),
    .scl_lo(scl_oe), .sda_lo(sda_oe)
  );

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {4'b0, ctrl_ie, ctrl_ack, ctrl_stop, ctrl_start};
      RA_STAT: reg_rdata = {nack, rxdir, master, bus_busy, ev_addr, ev_btf, ev_sb, evf};
      RA_DATA: reg_rdata = data_rx;
      default: reg_rdata = '0;
    endcase
  end

  // status read while an event is pending arms the clearing access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (!evf)  armed <= 1'b0;
    else if (sr_rd) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {ctrl_ie, ctrl_ack, ctrl_stop, ctrl_start} <= '0;
      {ev_sb, ev_addr, ev_btf, master, rxdir, nack} <= '0;
      data_tx <= '0;
      data_rx <= '0;
      cmd_go  <= 1'b0;
      cmd_sel <= CMD_START;
    end else begin
      cmd_go <= 1'b0;
      if (cr_wr) {ctrl_ie, ctrl_ack, ctrl_stop, ctrl_start} <= reg_wdata[3:0];
      if (dr_wr) data_tx <= reg_wdata;
      case (st)
        S_IDLE: if (ctrl_start) begin
          ctrl_start <= 1'b0;
          if (!bus_busy) begin
            master <= 1'b1; nack <= 1'b0; rxdir <= 1'b0;
            cmd_go <= 1'b1; cmd_sel <= CMD_START; st <= S_START;
          end
        end
        S_START: if (eng_done) begin ev_sb <= 1'b1; st <= S_EV_SB; end
        S_EV_SB: if (armed && dr_wr) begin
          ev_sb <= 1'b0; rxdir <= reg_wdata[0];
          cmd_go <= 1'b1; cmd_sel <= CMD_WRITE; st <= S_ADDR;
        end
        S_ADDR: if (eng_done) begin
          ev_addr <= 1'b1; nack <= !eng_ack; st <= S_EV_ADDR;
        end
        S_EV_ADDR: if (armed && cr_wr) begin
          ev_addr <= 1'b0;
          if (reg_wdata[1]) begin cmd_go <= 1'b1; cmd_sel <= CMD_STOP; st <= S_STOP; end
          else if (rxdir)   begin cmd_go <= 1'b1; cmd_sel <= CMD_READ; st <= S_XFER; end
          else              st <= S_TX_WAIT;
        end
        S_TX_WAIT: begin
          if (dr_wr) begin cmd_go <= 1'b1; cmd_sel <= CMD_WRITE; st <= S_XFER; end
          else if (cr_wr && reg_wdata[1]) begin cmd_go <= 1'b1; cmd_sel <= CMD_STOP; st <= S_STOP; end
        end
        S_XFER: if (eng_done) begin
          if (rxdir) begin
            data_rx <= eng_rbyte; ev_btf <= 1'b1; st <= S_EV_BTF;
          end else begin
            nack <= nack | !eng_ack;
            if (ctrl_stop) begin cmd_go <= 1'b1; cmd_sel <= CMD_STOP; st <= S_STOP; end
            else begin ev_btf <= 1'b1; st <= S_EV_BTF; end
          end
        end
        S_EV_BTF: if (armed) begin
          if (rxdir && dr_rd) begin
            ev_btf <= 1'b0; cmd_go <= 1'b1;
            if (ctrl_stop) begin cmd_sel <= CMD_STOP; st <= S_STOP; end
            else           begin cmd_sel <= CMD_READ; st <= S_XFER; end
          end else if (!rxdir && dr_wr) begin
            ev_btf <= 1'b0; cmd_go <= 1'b1; cmd_sel <= CMD_WRITE; st <= S_XFER;
          end else if (!rxdir && cr_wr && reg_wdata[1]) begin
            ev_btf <= 1'b0; cmd_go <= 1'b1; cmd_sel <= CMD_STOP; st <= S_STOP;
          end
        end
        S_STOP: if (eng_done) begin master <= 1'b0; ctrl_stop <= 1'b0; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_evt_master_chk.sv
module i2c_evt_master_chk (
  input logic clk,
  input logic rst_n,
  input logic evf,
  input logic sr_rd,
  input logic scl_oe,
  input logic sda_oe,
  input logic master,
  input logic busy,
  input logic irq
);
  logic seen_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_sr <= 1'b0;
    else if (!evf)  seen_sr <= 1'b0;
    else if (sr_rd) seen_sr <= 1'b1;
  end

  // R3
  evf_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evf && !seen_sr) |=> evf);

  // R2
  evf_stalls_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evf |-> scl_oe);

  // R2
  start_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master) |-> !$past(busy));

  // R8
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master) |-> (!scl_oe && !sda_oe));

  // R10
  irq_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> evf);
endmodule

bind i2c_evt_master i2c_evt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evf(evf), .sr_rd(sr_rd), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .master(master), .busy(bus_busy), .irq(irq)
);

// File: tb/i2c_evt_master_tb.sv
module i2c_evt_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SLV = 7'h52;
  localparam logic [1:0] A_CR = 2'd0, A_SR = 2'd1, A_DR = 2'd2;
  // row: [15] read, [14:8] address, [7:4] byte count, [0] slave expected to ack
  localparam logic [15:0] XFERS [0:5] = '{16'h5221, 16'hD231, 16'h1310,
                                          16'hD211, 16'hD221, 16'h5231};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic sl_lo = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || sl_lo);
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_evt_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_w), .scl_oe(scl_oe), .sda_in(sda_w), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] rdb(int i);
    return 8'(8'h3C + i * 8'h59);
  endfunction
  function automatic logic [7:0] txb(int r, int i);
    return 8'(8'hA7 ^ (r * 37) ^ (i * 91));
  endfunction

  // bus slave model
  logic p_scl = 1'b1, p_sda = 1'b1, sl_act = 1'b0, sl_rdm = 1'b0;
  int bitn = 0, bidx = 0, got_n = 0, stops = 0;
  logic [7:0] sh = '0, tmp;
  logic [7:0] got [0:15];
  logic mack [0:15];

  always @(scl_w, sda_w) begin
    if (scl_w && p_scl && p_sda && !sda_w) begin
      sl_act = 1'b1; bitn = -1; bidx = 0; got_n = 0; sl_rdm = 1'b0; sl_lo = 1'b0;
    end else if (scl_w && p_scl && !p_sda && sda_w) begin
      stops++; sl_act = 1'b0; sl_lo = 1'b0;
    end else if (scl_w && !p_scl && sl_act && bitn >= 0) begin
      if (bitn < 8) sh = {sh[6:0], sda_w};
      else if (sl_rdm && bidx > 0) begin
        mack[bidx-1] = !sda_w;
        if (sda_w) sl_act = 1'b0;
      end
    end else if (!scl_w && p_scl && sl_act) begin
      bitn++;
      if (bitn == 9) begin bitn = 0; bidx++; end
      sl_lo = 1'b0;
      if (bitn == 8) begin
        if (bidx == 0) begin
          sl_rdm = sh[0];
          if (sh[7:1] == SLV) sl_lo = 1'b1; else sl_act = 1'b0;
        end else if (!sl_rdm) begin
          got[bidx-1] = sh; got_n = bidx; sl_lo = 1'b1;
        end
      end else if (sl_rdm && bidx > 0) begin
        tmp = rdb(bidx - 1);
        sl_lo = !tmp[7-bitn];
      end
    end
    p_scl = scl_w;
    p_sda = sda_w;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_evf(output logic [7:0] s);
    int g = 0;
    do begin rd(A_SR, s); g++; end while (!s[0] && g < 5000);
  endtask

  task automatic wait_irq();
    int g = 0;
    while (!irq && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_idle(output logic [7:0] s);
    int g = 0;
    do begin rd(A_SR, s); g++; end while (s[5] && g < 5000);
    repeat (8) @(negedge clk);
    rd(A_SR, s);
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_SR, s); chk("R1", "status", s, 8'h00);
    rd(A_CR, s); chk("R1", "control", s, 8'h00);
    chk("R1", "lines/irq", {scl_oe, sda_oe, irq}, 3'b000);

    for (int r = 0; r < 6; r++) begin
      logic rdm, good;
      logic [6:0] ad;
      int n, st0;
      rdm = XFERS[r][15]; ad = XFERS[r][14:8]; n = int'(XFERS[r][7:4]); good = XFERS[r][0];
      st0 = stops;
      wr(A_CR, 8'h05);
      wait_evf(s);
      chk("R2", "SB/MASTER/BUSY", {s[5], s[4], s[1], s[0]}, 4'b1111);
      chk("R2", "scl held", scl_oe, 1'b1);
      wr(A_DR, {ad, rdm});
      wait_evf(s);
      chk("R4", "ADR event", {s[3], s[0]}, 2'b11);
      chk("R4", "NACK bit", s[7], !good);
      chk("R5", "RXDIR", s[6], rdm);
      if (!good) begin
        wr(A_CR, 8'h06);
      end else if (!rdm) begin
        wr(A_CR, 8'h04);
        for (int i = 0; i < n; i++) begin
          wr(A_DR, txb(r, i));
          if (i == n - 1) wr(A_CR, 8'h06);
          else begin wait_evf(s); chk("R6", "BTF", {s[2], s[0]}, 2'b11); end
        end
      end else begin
        wr(A_CR, (n == 1) ? 8'h00 : 8'h04);
        for (int i = 0; i < n; i++) begin
          wait_evf(s);
          chk("R7", "BTF", {s[2], s[0]}, 2'b11);
          if (i == n - 2) wr(A_CR, 8'h00);
          if (i == n - 1) wr(A_CR, 8'h02);
          rd(A_DR, d);
          chk("R7", "rx byte", d, rdb(i));
        end
      end
      wait_idle(s);
      chk("R8", "idle status", s[5:4], 2'b00);
      chk("R8", "stop seen", stops - st0, 1);
      chk("R8", "lines released", {scl_oe, sda_oe}, 2'b00);
      if (good && !rdm) begin
        chk("R6", "byte count", got_n, n);
        for (int i = 0; i < n; i++) chk("R6", "tx byte", got[i], txb(r, i));
      end
      if (good && rdm)
        for (int i = 0; i < n; i++) chk("R9", "master ack", mack[i], (i != n - 1));
    end

    // R3/R10: data write before any status read must not clear the start event
    wr(A_CR, 8'h0D);
    wait_irq();
    chk("R10", "irq on SB", irq, 1'b1);
    wr(A_DR, {SLV, 1'b0});
    held = 0;
    for (int k = 0; k < 64; k++) begin @(negedge clk); if (scl_oe && irq) held++; end
    chk("R3", "stall kept", held, 64);
    rd(A_SR, s);
    chk("R3", "SB still set", {s[1], s[0]}, 2'b11);
    wr(A_DR, {SLV, 1'b0});
    @(negedge clk);
    chk("R10", "irq drops", irq, 1'b0);
    wait_irq();
    rd(A_SR, s);
    chk("R4", "ADR after clear", {s[3], s[0]}, 2'b11);
    wr(A_CR, 8'h06);
    wait_idle(s);
    chk("R10", "irq off", irq, 1'b0);

    // R10: interrupt gated off
    wr(A_CR, 8'h01);
    wait_evf(s);
    chk("R10", "irq masked", irq, 1'b0);
    wr(A_DR, {SLV, 1'b1});
    wait_evf(s);
    chk("R10", "irq masked addr", irq, 1'b0);
    wr(A_CR, 8'h02);
    wait_idle(s);
    chk("R8", "final idle", {s[5], scl_oe, sda_oe}, 3'b000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule